// File: doc/BRIEF.md
# Processor Boot and Instruction Prefetch Sequencer

This block is the front end of a processor with a 16-bit data bus and a 32-bit address. After a synchronous reset it runs a fixed start-up sequence. First it keeps the bus quiet for a set time. It then reads four words from the bottom of memory to load the stack pointer and the program counter. Finally it fills a two-word instruction queue, so that the first opcode is ready for the decoder. One clock period is one half-clock of the bus. A microcycle is four clocks.

Every read has two parts. The address phase presents a new address. The data phase keeps that address and selects a word. Between the two phases the block waits for an acknowledge, given on any of three lines. An extra wait-state count from outside can lengthen the data phase. When the queue is full, the block raises a one-cycle decode-ready pulse. It then leaves the bus idle until the next reset. A reset at any time abandons the current access and starts the sequence again.

Top module: `cpu_boot_fetch`

## Requirements
- R1: After reset is released, the bus strobe `bus_as` stays low for exactly 28 clocks (7 microcycles of 4 clocks) before the first access.
- R2: Reset sets the status to supervisor (`sr_super`=1, `bus_super`=1), interrupt mask `sr_ipl`=7 and trace `sr_trace`=0.
- R3: The first four accesses read byte addresses 0, 2, 4 and 6 with `bus_prog`=0. Words 0 and 1 become the upper and lower halves of `sp_out`. Words 2 and 3 become the upper and lower halves of the program counter.
- R4: After the four vector reads, the block makes exactly two more accesses. The second follows a gap of 4 idle clocks (one microcycle). Exactly one `decode_rdy` pulse, one clock long, comes after the last access. There is no bus activity after it.
- R5: Each access begins with an address phase of 4 clocks, with `bus_new_addr`=1, and ends with a data phase, with `bus_ds`=1. The address is held for the whole access. Accesses other than those after the reset idle and after the gap are separated by one idle clock.
- R6: With `IMPLICIT_ACK`=0, acknowledge is checked in the last address-phase clock and then every second clock. Any one of `ack_dtack`, `ack_berr` or `ack_vpa` ends the wait. The wait lasts 0, 2, 4, ... clocks.
- R7: A prefetch reads the word at the program counter with `bus_prog`=1 and adds 2 to the program counter, wrapping at 32 bits. The queue's low word moves to the high word, and the new word goes into the low word.
- R8: When `decode_rdy` pulses, `opcode` equals the first prefetched word and `instr_addr` equals the program counter minus 4.
- R9: The data phase lasts 4 + `wait_states` clocks. `wait_states` is sampled when the data phase begins.
- R10: With `rst` high at a clock edge, `bus_as` is low from that edge on, whatever access was running. After release, the whole sequence runs again from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus half-clock per period |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 32 | Byte address of the current access |
| bus_as | output | 1 | High for the whole of an access |
| bus_new_addr | output | 1 | Address phase of an access |
| bus_ds | output | 1 | Data phase, word selected |
| bus_rd | output | 1 | Read direction; every access is a read |
| bus_prog | output | 1 | 1 = program space, 0 = data space |
| bus_super | output | 1 | Supervisor indicator for the bus |
| bus_rdata | input | 16 | Read data, taken in the last data-phase clock |
| ack_dtack | input | 1 | Data acknowledge |
| ack_berr | input | 1 | Bus error, used here only to end the wait |
| ack_vpa | input | 1 | Peripheral acknowledge, used here only to end the wait |
| wait_states | input | 4 | Extra clocks added to the data phase |
| sp_out | output | 32 | Loaded supervisor stack pointer |
| pc_out | output | 32 | Program counter |
| sr_super | output | 1 | Supervisor status bit |
| sr_ipl | output | 3 | Interrupt mask level |
| sr_trace | output | 1 | Trace status bit |
| opcode | output | 16 | Opcode given to the decoder |
| instr_addr | output | 32 | Address of that opcode |
| decode_rdy | output | 1 | One-clock pulse when the opcode is valid |

## Verification
The embedded properties check these behaviours on every cycle:
- A wait phase is entered only after a missing acknowledge, and left only after a present one.
- A new access starts only while the bus engine is idle.
- Each prefetch adds exactly 2 to the program counter.
- The space indicator matches the sequence step.
- The decode pulse lasts one clock.
- Right after reset the status is supervisor, mask 7 and no trace, with the bus quiet.

Only the bench scenarios show the counted lengths: the 28-clock start idle, the 4-clock gap, the per-access wait and data lengths under different acknowledge latencies and lines, and the exact addresses and loaded values. They also show the program counter wrapping at the top of memory and the full restart after a reset that lands inside a data phase.

// File: rtl/cbf_pkg.sv
`timescale 1ns/1ps
package cbf_pkg;
  // Phase of the word-access engine.
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WAIT, PH_DATA} phase_t;
  // Top-level boot sequencer state.
  typedef enum logic [2:0] {SQ_IDLE, SQ_ISSUE, SQ_BUSY, SQ_GAP, SQ_DECODE, SQ_HALT} seq_t;
endpackage

// File: rtl/cbf_bus_cycle.sv
`timescale 1ns/1ps
module cbf_bus_cycle
  import cbf_pkg::*;
#(
  parameter int AW           = 32,
  parameter int WS_W         = 4,
  parameter int ADDR_HC      = 4,
  parameter int STEP_HC      = 2,
  parameter int DATA_HC      = 4,
  parameter bit IMPLICIT_ACK = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_prog,
  input  logic          ack_any,
  input  logic [WS_W-1:0] wait_states,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic          bus_prog,
  output logic          bus_new_addr,
  output logic          bus_ds,
  output logic          bus_as
);
  localparam int CNT_W = $clog2(ADDR_HC + STEP_HC + DATA_HC + (1 << WS_W)) + 1;
  localparam logic [CNT_W-1:0] ADDR_LOAD = CNT_W'(ADDR_HC - 1);
  localparam logic [CNT_W-1:0] STEP_LOAD = CNT_W'(STEP_HC - 1);
  localparam logic [CNT_W-1:0] DATA_LOAD = CNT_W'(DATA_HC - 1);

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    addr_q;
  logic             prog_q;
  logic             go_data;

  // Acknowledge is only looked at on a checkpoint (counter expiry).
  assign go_data = IMPLICIT_ACK || ack_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      prog_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_ADDR;
          cnt    <= ADDR_LOAD;
          addr_q <= start_addr;
          prog_q <= start_prog;
        end
        PH_ADDR, PH_WAIT: begin
          if (cnt == '0) begin
            if (go_data) begin
              ph  <= PH_DATA;
              cnt <= DATA_LOAD + CNT_W'(wait_states);
            end else begin
              ph  <= PH_WAIT;
              cnt <= STEP_LOAD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt == '0) ph <= PH_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign done         = (ph == PH_DATA) && (cnt == '0);
  assign busy         = (ph != PH_IDLE);
  assign bus_addr     = addr_q;
  assign bus_prog     = prog_q;
  assign bus_new_addr = (ph == PH_ADDR);
  assign bus_ds       = (ph == PH_DATA);
  assign bus_as       = busy;

  AST_WAIT_ENTRY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WAIT && $past(cnt) == '0 && $past(ph) != PH_IDLE && $past(ph) != PH_DATA)
      |-> !$past(ack_any)); // R6
  AST_DATA_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DATA && $past(ph) != PH_DATA) |-> (IMPLICIT_ACK || $past(ack_any))); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_addr)); // R5
  AST_ACCESS_OPENS: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ADDR && $past(ph) != PH_ADDR) |-> $past(start)); // R5
endmodule

// File: rtl/cbf_prefetch_q.sv
`timescale 1ns/1ps
module cbf_prefetch_q #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q_hi,
  output logic [DW-1:0] q_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_hi <= '0;
      q_lo <= '0;
    end else if (push) begin
      q_hi <= q_lo;
      q_lo <= din;
    end
  end

  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    push |=> (q_hi == $past(q_lo) && q_lo == $past(din))); // R7
endmodule

// File: rtl/cpu_boot_fetch.sv
`timescale 1ns/1ps
module cpu_boot_fetch
  import cbf_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 16,
  parameter int WS_W         = 4,
  parameter int MC_HC        = 4,
  parameter int IDLE_MC      = 7,
  parameter int GAP_MC       = 1,
  parameter bit IMPLICIT_ACK = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_as,
  output logic            bus_new_addr,
  output logic            bus_ds,
  output logic            bus_rd,
  output logic            bus_prog,
  output logic            bus_super,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            ack_dtack,
  input  logic            ack_berr,
  input  logic            ack_vpa,
  input  logic [WS_W-1:0] wait_states,
  output logic [AW-1:0]   sp_out,
  output logic [AW-1:0]   pc_out,
  output logic            sr_super,
  output logic [2:0]      sr_ipl,
  output logic            sr_trace,
  output logic [DW-1:0]   opcode,
  output logic [AW-1:0]   instr_addr,
  output logic            decode_rdy
);
  localparam int IDLE_HC = IDLE_MC * MC_HC;
  localparam int GAP_HC  = GAP_MC * MC_HC;
  localparam int TW      = $clog2(IDLE_HC + GAP_HC + 1);
  // The ISSUE cycle is one more quiet cycle, so counters load two short.
  localparam logic [TW-1:0] IDLE_LOAD = TW'(IDLE_HC - 2);
  localparam logic [TW-1:0] GAP_LOAD  = TW'(GAP_HC - 2);
  localparam int  QW = 2;  // queue words
  localparam logic [2:0] LAST_VEC = 3'd3;
  localparam logic [2:0] FIRST_PF = 3'd4;
  localparam logic [2:0] LAST_PF  = 3'(4 + QW - 1);

  seq_t          state;
  logic [TW-1:0] tcnt;
  logic [2:0]    step;
  logic [AW-1:0] sp_q, pc_q, ia_q;
  logic [DW-1:0] op_q, q_hi, q_lo;
  logic          dec_q, sup_q, trace_q;
  logic [2:0]    ipl_q;
  logic          cyc_start, cyc_done, cyc_busy, ack_any, pf_push;
  logic [AW-1:0] start_addr;

  assign ack_any    = ack_dtack | ack_berr | ack_vpa;
  assign cyc_start  = (state == SQ_ISSUE);
  assign start_addr = step[2] ? pc_q : {{(AW-3){1'b0}}, step[1:0], 1'b0};
  assign pf_push    = cyc_done && (state == SQ_BUSY) && step[2];

  cbf_bus_cycle #(
    .AW(AW), .WS_W(WS_W), .ADDR_HC(MC_HC), .STEP_HC(MC_HC / 2),
    .DATA_HC(MC_HC), .IMPLICIT_ACK(IMPLICIT_ACK)
  ) u_cycle (
    .clk(clk), .rst(rst), .start(cyc_start), .start_addr(start_addr),
    .start_prog(step[2]), .ack_any(ack_any), .wait_states(wait_states),
    .done(cyc_done), .busy(cyc_busy), .bus_addr(bus_addr), .bus_prog(bus_prog),
    .bus_new_addr(bus_new_addr), .bus_ds(bus_ds), .bus_as(bus_as)
  );

  cbf_prefetch_q #(.DW(DW)) u_queue (
    .clk(clk), .rst(rst), .push(pf_push), .din(bus_rdata), .q_hi(q_hi), .q_lo(q_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      tcnt    <= IDLE_LOAD;
      step    <= '0;
      sp_q    <= '0;
      pc_q    <= '0;
      op_q    <= '0;
      ia_q    <= '0;
      dec_q   <= 1'b0;
      sup_q   <= 1'b1;
      ipl_q   <= 3'd7;
      trace_q <= 1'b0;
    end else begin
      dec_q <= 1'b0;
      case (state)
        SQ_IDLE, SQ_GAP: begin
          if (tcnt == '0) state <= SQ_ISSUE;
          else            tcnt  <= tcnt - 1'b1;
        end
        SQ_ISSUE: state <= SQ_BUSY;
        SQ_BUSY: if (cyc_done) begin
          case (step)
            3'd0: sp_q[AW-1:DW] <= bus_rdata;
            3'd1: sp_q[DW-1:0]  <= bus_rdata;
            3'd2: pc_q[AW-1:DW] <= bus_rdata;
            3'd3: pc_q[DW-1:0]  <= bus_rdata;
            default: pc_q <= pc_q + AW'(2);
          endcase
          if (step == LAST_PF) begin
            state <= SQ_DECODE;
          end else if (step == FIRST_PF) begin
            state <= SQ_GAP;
            tcnt  <= GAP_LOAD;
            step  <= step + 1'b1;
          end else begin
            state <= SQ_ISSUE;
            step  <= (step == LAST_VEC) ? FIRST_PF : step + 1'b1;
          end
        end
        SQ_DECODE: begin
          op_q  <= q_hi;
          ia_q  <= pc_q - AW'(4);
          dec_q <= 1'b1;
          state <= SQ_HALT;
        end
        default: state <= SQ_HALT;
      endcase
    end
  end

  assign bus_rd     = bus_as;
  assign bus_super  = sup_q;
  assign sp_out     = sp_q;
  assign pc_out     = pc_q;
  assign sr_super   = sup_q;
  assign sr_ipl     = ipl_q;
  assign sr_trace   = trace_q;
  assign opcode     = op_q;
  assign instr_addr = ia_q;
  assign decode_rdy = dec_q;

  AST_RESET_STATUS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sr_super && sr_ipl == 3'd7 && !sr_trace)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !bus_as); // R10
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> !cyc_busy); // R5
  AST_VECTOR_SPACE: assert property (@(posedge clk) disable iff (rst)
    (bus_as && !step[2]) |-> !bus_prog); // R3
  AST_PREFETCH_SPACE: assert property (@(posedge clk) disable iff (rst)
    (bus_as && step[2]) |-> bus_prog); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    pf_push |=> (pc_q == $past(pc_q) + AW'(2))); // R7
  AST_DECODE_PULSE: assert property (@(posedge clk) disable iff (rst)
    decode_rdy |=> !decode_rdy); // R4
endmodule

// File: tb/cpu_boot_fetch_tb.sv
`timescale 1ns/1ps
module cpu_boot_fetch_tb;
  localparam int AW = 32, DW = 16, WS_W = 4, NT = 5;
  // Fields: latency[77:70], ack line[69:68], wait states[67:64], sp[63:32], pc[31:0]
  localparam logic [77:0] TBL [NT] = '{
    {8'd0,  2'd0, 4'd0,  32'h00FF_0100, 32'h0000_0400},
    {8'd4,  2'd1, 4'd2,  32'h1234_5678, 32'h0001_0000},
    {8'd5,  2'd2, 4'd0,  32'h8000_0000, 32'h00FF_FFFC},
    {8'd7,  2'd0, 4'd5,  32'hCAFE_0002, 32'h0000_0008},
    {8'd40, 2'd0, 4'd15, 32'h0000_FFFE, 32'hFFFF_FFFC}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [AW-1:0] bus_addr, sp_out, pc_out, instr_addr;
  logic bus_as, bus_new_addr, bus_ds, bus_rd, bus_prog, bus_super;
  logic [DW-1:0] bus_rdata, opcode;
  logic ack_dtack, ack_berr, ack_vpa, sr_super, sr_trace, decode_rdy;
  logic [2:0] sr_ipl;
  logic [WS_W-1:0] ws = '0;
  logic [1:0] ack_sel = '0;
  int lat = 0;
  logic ack_on = 1'b0;
  logic [15:0] vec [4];

  int checks = 0, fails = 0;

  cpu_boot_fetch u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_as(bus_as),
    .bus_new_addr(bus_new_addr), .bus_ds(bus_ds), .bus_rd(bus_rd),
    .bus_prog(bus_prog), .bus_super(bus_super), .bus_rdata(bus_rdata),
    .ack_dtack(ack_dtack), .ack_berr(ack_berr), .ack_vpa(ack_vpa),
    .wait_states(ws), .sp_out(sp_out), .pc_out(pc_out), .sr_super(sr_super),
    .sr_ipl(sr_ipl), .sr_trace(sr_trace), .opcode(opcode),
    .instr_addr(instr_addr), .decode_rdy(decode_rdy)
  );

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    if (a < 32'd8) return vec[a[2:1]];
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  always_comb bus_rdata = mem_word(bus_addr);
  assign ack_dtack = ack_on && (ack_sel == 2'd0);
  assign ack_berr  = ack_on && (ack_sel == 2'd1);
  assign ack_vpa   = ack_on && (ack_sel == 2'd2);

  // Bus monitor and acknowledge model, sampled away from the active edge.
  int n_acc = 0, gap = 0, la = 0, lw = 0, ld = 0, dec_cnt = 0, as_cnt = 0;
  bit in_acc = 0;
  int a_gap [8], a_la [8], a_lw [8], a_ld [8];
  logic [31:0] a_addr [8];
  logic a_prog [8];
  logic [15:0] cap_op;
  logic [31:0] cap_ia;

  always @(negedge clk) begin
    if (rst) begin
      n_acc = 0; gap = 0; in_acc = 0; dec_cnt = 0; as_cnt = 0; ack_on = 1'b0;
    end else begin
      if (bus_as) begin
        ack_on = (as_cnt >= lat);
        as_cnt++;
        if (!in_acc) begin
          in_acc = 1;
          if (n_acc < 8) begin
            a_gap[n_acc] = gap; a_addr[n_acc] = bus_addr; a_prog[n_acc] = bus_prog;
          end
          la = 0; lw = 0; ld = 0; gap = 0;
        end
        if (bus_new_addr) la++;
        else if (bus_ds) ld++;
        else lw++;
      end else begin
        ack_on = 1'b0; as_cnt = 0; gap++;
        if (in_acc) begin
          in_acc = 0;
          if (n_acc < 8) begin
            a_la[n_acc] = la; a_lw[n_acc] = lw; a_ld[n_acc] = ld;
          end
          n_acc++;
        end
      end
      if (decode_rdy) begin
        dec_cnt++; cap_op = opcode; cap_ia = instr_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int exp_wait(input int l);
    int c = 3;
    while (c < l) c += 2;
    return c - 3;
  endfunction

  task automatic load_entry(input int i, output logic [31:0] sp0, output logic [31:0] pc0);
    lat = int'(TBL[i][77:70]);
    ack_sel = TBL[i][69:68];
    ws = TBL[i][67:64];
    sp0 = TBL[i][63:32];
    pc0 = TBL[i][31:0];
    vec[0] = sp0[31:16]; vec[1] = sp0[15:0]; vec[2] = pc0[31:16]; vec[3] = pc0[15:0];
  endtask

  task automatic pulse_reset();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic verify_run(input logic [31:0] sp0, input logic [31:0] pc0);
    while (dec_cnt == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(n_acc == 6, "R4 access count", n_acc, 6);
    chk(dec_cnt == 1, "R4 decode pulses", dec_cnt, 1);
    chk(a_gap[0] == 28, "R1 start idle", a_gap[0], 28);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] ea;
      ea = (k < 4) ? 32'(2 * k) : pc0 + 32'(2 * (k - 4));
      chk(a_addr[k] == ea, (k < 4) ? "R3 vector address" : "R7 prefetch address", a_addr[k], ea);
      chk(a_prog[k] == (k >= 4), (k < 4) ? "R3 data space" : "R7 program space", 32'(a_prog[k]), 32'(k >= 4));
      chk(a_la[k] == 4, "R5 address phase", a_la[k], 4);
      chk(a_lw[k] == exp_wait(lat), "R6 wait length", a_lw[k], exp_wait(lat));
      chk(a_ld[k] == 4 + int'(ws), "R9 data phase", a_ld[k], 4 + int'(ws));
      if (k > 0) chk(a_gap[k] == ((k == 5) ? 4 : 1), (k == 5) ? "R4 idle microcycle" : "R5 turnaround", a_gap[k], (k == 5) ? 4 : 1);
    end
    chk(sp_out == sp0, "R3 stack pointer", sp_out, sp0);
    chk(pc_out == pc0 + 32'd4, "R7 program counter", pc_out, pc0 + 32'd4);
    chk(cap_op == mem_word(pc0), "R8 opcode", 32'(cap_op), 32'(mem_word(pc0)));
    chk(cap_ia == pc0, "R8 instruction address", cap_ia, pc0);
    chk(opcode == mem_word(pc0), "R8 opcode held", 32'(opcode), 32'(mem_word(pc0)));
    chk(sr_super && bus_super && sr_ipl == 3'd7 && !sr_trace, "R2 status after boot",
        {28'd0, sr_super, sr_ipl}, 32'hF);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] sp0, pc0;
    load_entry(0, sp0, pc0);
    // Reset state (R2, R10)
    repeat (3) @(negedge clk);
    chk(!bus_as, "R10 bus quiet in reset", 32'(bus_as), 0);
    chk(!decode_rdy, "R4 no pulse in reset", 32'(decode_rdy), 0);
    chk(sr_super && bus_super, "R2 supervisor", 32'(sr_super), 1);
    chk(sr_ipl == 3'd7, "R2 mask", 32'(sr_ipl), 7);
    chk(!sr_trace, "R2 trace", 32'(sr_trace), 0);

    // Table walk: several latencies, acknowledge lines, wait states, address wrap.
    for (int i = 0; i < NT; i++) begin
      load_entry(i, sp0, pc0);
      pulse_reset();
      verify_run(sp0, pc0);
    end

    // Reset lands inside the data phase of the third vector read (R10).
    load_entry(1, sp0, pc0);
    pulse_reset();
    @(negedge clk);
    while (!(bus_ds && n_acc == 2)) @(negedge clk);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!bus_as, "R10 access abandoned", 32'(bus_as), 0);
    @(posedge clk); #1 rst = 1'b0;
    verify_run(sp0, pc0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule